// File: doc/BRIEF.md
# UART command, status and interrupt flag unit

This block is the control and interrupt core of a UART peripheral. Software reaches it through a flat 32-bit register port with no wait states: a write is taken on the clock edge when the write strobe is high, and a read returns the word at the presented address in the same cycle. The block holds the receiver and transmitter enables. These change only through one-cycle command strobes written to a command address. It also holds a small control word, an interrupt enable mask and a set of interrupt flags.

Each flag can be raised by a hardware event from the serial datapaths, raised by writing ones to a set alias, or lowered by writing ones to a clear alias. The transmit buffer level flag is the exception: it follows the transmitter's buffer level. Two interrupt lines leave the block. One serves receive events and the other serves transmit events. Each line is the OR of its own flags, gated by the enable mask. The serial shifters and the baud generator sit outside this block and reach it through its event and level inputs.

Top module: `uart_ctl_irq`

## Requirements
- R1: After reset, both enables, both control bits, the enable mask, all flags and both interrupt lines are zero.
- R2: A write to offset 0x0C sets the receive enable when bit 0 is one and sets the transmit enable when bit 2 is one. A bit written as zero leaves its enable unchanged, and with no write the enables hold.
- R3: In a write to 0x0C, bit 1 clears the receive enable and bit 3 clears the transmit enable. When the enable bit and the disable bit of the same direction are both one, the enable ends up cleared.
- R4: The flag word at 0x40 holds transmit complete in bit 0, transmit buffer level in bit 1, receive data valid in bit 2 and receive overflow in bit 4, and reads zero elsewhere. For bits 0, 2 and 4, writing ones to 0x44 sets them and writing ones to 0x48 clears them. Zeros written to either alias change nothing.
- R5: The transmit-done, receive-valid and receive-overflow event pulses set flag bits 0, 2 and 4 on the next edge. An event in the same cycle as a clear write of its bit leaves the bit set.
- R6: The receive interrupt line is high exactly when flag bit 2 or flag bit 4 is set together with its mask bit. The transmit interrupt line does the same for flag bits 0 and 1.
- R7: Flag bit 1 equals the transmit buffer level input sampled on the previous edge. Set and clear writes do not affect it.
- R8: Reads of 0x0C, 0x44 and 0x48, and of any unmapped offset, return zero.
- R9: Offset 0x00 stores bit 0 (synchronous mode) and bit 12 (buffer level threshold select). Both drive outputs and read back, and all other bits read zero.
- R10: Offset 0x4C stores the enable mask in bits 0, 1, 2 and 4. Other written bits are dropped and read back as zero.
- R11: The status word at 0x10 shows the receive enable in bit 0, the transmit enable in bit 1, the transmitter idle input in bit 5, the buffer level input in bit 6 and the receive data present input in bit 7. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| rx_valid_ev | input | 1 | Receiver pulse: a character arrived |
| rx_ovf_ev | input | 1 | Receiver pulse: a character was lost |
| tx_done_ev | input | 1 | Transmitter pulse: the last frame finished |
| tx_buf_lvl | input | 1 | Transmit buffer at or below threshold |
| tx_idle | input | 1 | Transmitter has nothing left to send |
| rx_has_data | input | 1 | Receive buffer holds data |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| sync_mode | output | 1 | Synchronous mode select |
| lvl_sel | output | 1 | Buffer level threshold select |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The collision of interest is a hardware event pulse landing in the same cycle as a software write to the clear alias for the same flag. The bench forces it on purpose in directed steps and also lets it occur in a long random phase, where events and clear writes are drawn independently. The expected result is that the flag survives with its interrupt line still high, while a clear of a flag with no event drops it. The same holds for a command write that carries both the enable and disable bit of one direction, which must leave that direction disabled.

// File: rtl/uart_ctl_irq.sv
module uart_ctl_irq #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid_ev,
  input  logic              rx_ovf_ev,
  input  logic              tx_done_ev,
  input  logic              tx_buf_lvl,
  input  logic              tx_idle,
  input  logic              rx_has_data,
  output logic              rx_en,
  output logic              tx_en,
  output logic              sync_mode,
  output logic              lvl_sel,
  output logic              irq_rx,
  output logic              irq_tx
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_CMD  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_FLAG = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] OFS_SET  = ADDR_W'('h44);
  localparam logic [ADDR_W-1:0] OFS_CLR  = ADDR_W'('h48);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'('h4C);
  localparam logic [4:0] FLAG_BITS   = 5'b10111;
  localparam logic [4:0] STICKY_BITS = 5'b10101;

  logic [4:0] flag, ien, hw_ev, sw_set, sw_clr, sticky_nxt;

  wire wr_ctrl = bus_we && bus_addr == OFS_CTRL;
  wire wr_cmd  = bus_we && bus_addr == OFS_CMD;
  wire wr_set  = bus_we && bus_addr == OFS_SET;
  wire wr_clr  = bus_we && bus_addr == OFS_CLR;
  wire wr_mask = bus_we && bus_addr == OFS_MASK;

  assign hw_ev      = {rx_ovf_ev, 1'b0, rx_valid_ev, 1'b0, tx_done_ev};
  assign sw_set     = wr_set ? bus_wdata[4:0] & STICKY_BITS : 5'b0;
  assign sw_clr     = wr_clr ? bus_wdata[4:0] & STICKY_BITS : 5'b0;
  assign sticky_nxt = (flag | hw_ev | sw_set) & ~(sw_clr & ~hw_ev) & STICKY_BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag      <= '0;
      ien       <= '0;
      rx_en     <= 1'b0;
      tx_en     <= 1'b0;
      sync_mode <= 1'b0;
      lvl_sel   <= 1'b0;
    end else begin
      flag <= sticky_nxt | {3'b0, tx_buf_lvl, 1'b0};
      if (wr_mask) ien <= bus_wdata[4:0] & FLAG_BITS;
      if (wr_ctrl) begin
        sync_mode <= bus_wdata[0];
        lvl_sel   <= bus_wdata[12];
      end
      if (wr_cmd) begin
        if (bus_wdata[1])      rx_en <= 1'b0;
        else if (bus_wdata[0]) rx_en <= 1'b1;
        if (bus_wdata[3])      tx_en <= 1'b0;
        else if (bus_wdata[2]) tx_en <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[0]  = sync_mode;
        bus_rdata[12] = lvl_sel;
      end
      OFS_STAT: begin
        bus_rdata[0] = rx_en;
        bus_rdata[1] = tx_en;
        bus_rdata[5] = tx_idle;
        bus_rdata[6] = tx_buf_lvl;
        bus_rdata[7] = rx_has_data;
      end
      OFS_FLAG: bus_rdata[4:0] = flag;
      OFS_MASK: bus_rdata[4:0] = ien;
      default:  bus_rdata = '0;
    endcase
  end

  wire [4:0] live = flag & ien;
  assign irq_rx = live[2] | live[4];
  assign irq_tx = live[0] | live[1];
endmodule

// File: rtl/uart_ctl_irq_chk.sv
module uart_ctl_irq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              rx_valid_ev,
  input logic              rx_ovf_ev,
  input logic              tx_buf_lvl,
  input logic              rx_en,
  input logic              tx_en,
  input logic              irq_rx,
  input logic              irq_tx,
  input logic [4:0]        flag,
  input logic [4:0]        ien
);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'('h44);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'('h48);

  a_r2_rx_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CMD && bus_wdata[0] && !bus_wdata[1]) |=> rx_en);
  a_r3_rx_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CMD && bus_wdata[1]) |=> !rx_en);
  a_r3_tx_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CMD && bus_wdata[3]) |=> !tx_en);
  a_r5_valid_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_ev |=> flag[2]);
  a_r5_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf_ev |=> flag[4]);
  a_r6_rx_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien[2] && !ien[4]) |-> !irq_rx);
  a_r6_tx_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien[0] && !ien[1]) |-> !irq_tx);
  a_r7_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> flag[1] == $past(tx_buf_lvl));
  a_r8_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CMD || bus_addr == A_SET || bus_addr == A_CLR) |-> bus_rdata == 32'h0);
endmodule

bind uart_ctl_irq uart_ctl_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid_ev(rx_valid_ev),
  .rx_ovf_ev(rx_ovf_ev), .tx_buf_lvl(tx_buf_lvl), .rx_en(rx_en), .tx_en(tx_en),
  .irq_rx(irq_rx), .irq_tx(irq_tx), .flag(flag), .ien(ien)
);

// File: tb/sim_uart_ctl_irq.sv
`timescale 1ns/1ps
module sim_uart_ctl_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic we = 1'b0;
  logic [31:0] wd = '0, rdata;
  logic ev_valid = 0, ev_ovf = 0, ev_done = 0, lvl = 0, idle = 0, has_data = 0;
  logic rx_en, tx_en, sync_mode, lvl_sel, irq_rx, irq_tx;
  int total = 0, fails = 0;
  bit live_cmp = 0, done = 0;

  always #2 clk = ~clk;

  uart_ctl_irq u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wd),
    .bus_rdata(rdata), .rx_valid_ev(ev_valid), .rx_ovf_ev(ev_ovf),
    .tx_done_ev(ev_done), .tx_buf_lvl(lvl), .tx_idle(idle),
    .rx_has_data(has_data), .rx_en(rx_en), .tx_en(tx_en),
    .sync_mode(sync_mode), .lvl_sel(lvl_sel), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  // reference model
  bit m_rx, m_tx, m_sync, m_lvl;
  bit [4:0] m_flag, m_ien;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rx = 0; m_tx = 0; m_sync = 0; m_lvl = 0; m_flag = 0; m_ien = 0;
    end else begin
      bit [4:0] nf;
      nf = m_flag;
      nf[1] = lvl;
      if (we && addr == 8'h44) begin
        if (wd[0]) nf[0] = 1; if (wd[2]) nf[2] = 1; if (wd[4]) nf[4] = 1;
      end
      if (we && addr == 8'h48) begin
        if (wd[0]) nf[0] = 0; if (wd[2]) nf[2] = 0; if (wd[4]) nf[4] = 0;
      end
      if (ev_done)  nf[0] = 1;
      if (ev_valid) nf[2] = 1;
      if (ev_ovf)   nf[4] = 1;
      m_flag = nf;
      if (we && addr == 8'h4C) m_ien = {wd[4], 1'b0, wd[2:0]};
      if (we && addr == 8'h00) begin m_sync = wd[0]; m_lvl = wd[12]; end
      if (we && addr == 8'h0C) begin
        if (wd[0]) m_rx = 1; if (wd[1]) m_rx = 0;
        if (wd[2]) m_tx = 1; if (wd[3]) m_tx = 0;
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] r = 0;
    case (a)
      8'h00: begin r[0] = m_sync; r[12] = m_lvl; end
      8'h10: begin r[0] = m_rx; r[1] = m_tx; r[5] = idle; r[6] = lvl; r[7] = has_data; end
      8'h40: r[4:0] = m_flag;
      8'h4C: r[4:0] = m_ien;
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    case (a)
      8'h00: return "R9";
      8'h10: return "R11";
      8'h40: return "R4 R5 R7";
      8'h4C: return "R10";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always begin
    @(negedge clk); #1;
    if (live_cmp && rst_n) begin
      chk("R2 R3 rx_en", rx_en, m_rx);
      chk("R2 R3 tx_en", tx_en, m_tx);
      chk("R9 ctrl out", {sync_mode, lvl_sel}, {m_sync, m_lvl});
      chk("R6 irq_rx", irq_rx, (m_flag[2] & m_ien[2]) | (m_flag[4] & m_ien[4]));
      chk("R6 irq_tx", irq_tx, (m_flag[0] & m_ien[0]) | (m_flag[1] & m_ien[1]));
      chk(rd_tag(addr), rdata, m_read(addr));
    end
  end

  task automatic cyc(input logic [7:0] a, input bit w, input logic [31:0] d, input logic [2:0] ev);
    @(negedge clk);
    addr = a; we = w; wd = d; {ev_ovf, ev_valid, ev_done} = ev;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; we = 0; wd = 0; {ev_ovf, ev_valid, ev_done} = 0;
    #1 chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset outputs", {rx_en, tx_en, sync_mode, lvl_sel, irq_rx, irq_tx}, 0);
    rst_n = 1;
    rd_chk(8'h40, 0, "R1 flags");
    rd_chk(8'h4C, 0, "R1 mask");
    live_cmp = 1;
    cyc(8'h00, 1, 32'hFFFF_FFFF, 0);
    rd_chk(8'h00, 32'h0000_1001, "R9 ctrl readback");
    cyc(8'h0C, 1, 32'h5, 0);
    rd_chk(8'h10, 32'h3, "R2 R11 both enabled");
    cyc(8'h0C, 1, 32'h0, 0);
    rd_chk(8'h10, 32'h3, "R2 hold on zero write");
    cyc(8'h0C, 1, 32'hF, 0);
    rd_chk(8'h10, 32'h0, "R3 disable wins");
    cyc(8'h4C, 1, 32'hFFFF_FFFF, 0);
    rd_chk(8'h4C, 32'h17, "R10 mask bits");
    cyc(8'h40, 0, 0, 3'b010);
    rd_chk(8'h40, 32'h4, "R5 valid event");
    chk("R6 irq_rx raised", irq_rx, 1);
    cyc(8'h48, 1, 32'h4, 3'b010);
    rd_chk(8'h40, 32'h4, "R5 event beats clear");
    cyc(8'h48, 1, 32'h4, 0);
    rd_chk(8'h40, 32'h0, "R4 clear alias");
    cyc(8'h44, 1, 32'hFFFF_FFFF, 0);
    rd_chk(8'h40, 32'h15, "R4 set alias");
    chk("R6 irq_tx raised", irq_tx, 1);
    cyc(8'h4C, 1, 32'h0, 0);
    rd_chk(8'h40, 32'h15, "R6 flags kept");
    chk("R6 masked lines", {irq_rx, irq_tx}, 0);
    cyc(8'h48, 1, 32'hFF, 0);
    @(negedge clk); lvl = 1; addr = 8'h40; we = 0;
    rd_chk(8'h40, 32'h2, "R7 level flag");
    cyc(8'h48, 1, 32'h2, 0);
    rd_chk(8'h40, 32'h2, "R7 clear ignored");
    @(negedge clk); lvl = 0;
    rd_chk(8'h40, 32'h0, "R7 level drop");
    idle = 1; has_data = 1;
    rd_chk(8'h10, 32'hA0, "R11 status inputs");
    rd_chk(8'h0C, 0, "R8 cmd read");
    rd_chk(8'h44, 0, "R8 set read");
    rd_chk(8'h48, 0, "R8 clr read");
    rd_chk(8'h24, 0, "R8 unmapped read");
    for (int i = 0; i < 600; i++) begin
      logic [7:0] pick[8] = '{8'h00, 8'h0C, 8'h10, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h2C};
      @(negedge clk);
      addr = pick[$urandom_range(7)];
      we = $urandom_range(1);
      wd = $urandom;
      {ev_ovf, ev_valid, ev_done} = 3'($urandom_range(7) & $urandom_range(7));
      lvl = $urandom_range(1); idle = $urandom_range(1); has_data = $urandom_range(1);
    end
    cyc(8'h40, 0, 0, 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule